// File: doc/BRIEF.md
# Multi-Subsystem Sleep State Arbiter

This controller merges the power wishes of two processing subsystems into a single chip-level power state. One is the application processor and the other is the network/radio side. Each subsystem presents a request code. The application side can also ask for hibernation. Each subsystem has its own wake line. From these the controller drives four things: a chip-state code, a regulator level select, oscillator and PLL enables, and one reset-hold line per subsystem.

A subsystem that asks for deep sleep gets it at once in a virtual sense: it is put into reset-hold while the chip stays fully powered for the other side. The chip performs a real power-down only when both subsystems are held. Power-down is a fixed sequence that waits on the regulator's reported level. Power-up is the reverse sequence, with an oscillator settle count and a wait for PLL lock. After power-up, only the subsystem whose wake line fired leaves reset.

The regulator and the PLL are external and are represented by two inputs: the regulator's reported level and the PLL lock flag.

Top module: `pwr_arbiter`

## Requirements
- R1: Request codes are 00 run, 01 idle, 10 deep sleep, and 11 (treated like run). Chip-state codes are 00 active, 01 deep, 10 hibernate, and 11 in transition. Level codes are 00 off, 01 low (0.9 V) and 10 high (1.2 V). After reset the chip is active (state 00, level 10, oscillator and PLL enabled) with no subsystem held. The chip stays active while either subsystem is not held.
- R2: When a subsystem's request changes to 10 while the chip is active, its hold output rises on the next cycle. The chip stays active.
- R3: When both subsystems are held and no wake is pending, the controller powers down in this order. First the PLL enable drops. On the next cycle the oscillator enable drops. On the cycle after that the level select goes to 01. The state code reads 11 throughout. The state becomes 01 one cycle after the regulator level input first reads 01. In deep state both holds are high and both enables are low.
- R4: A wake on a held subsystem starts power-up in this order. The level select goes to 10 and the controller waits for the regulator level input to read 10. The oscillator is then enabled for exactly OSC_SETTLE cycles before the PLL is enabled. The controller then waits for the PLL lock flag, after which the state reads 00. The waking subsystem's hold drops one cycle after the state first reads 00, never earlier.
- R5: A subsystem with no wake of its own stays held after the chip returns to active.
- R6: A wake arriving during power-down aborts it. The chip goes back to active without reaching deep state, and the waking subsystem is released.
- R7: A wake on a subsystem that is not held has no effect.
- R8: A hibernate request while the application side is not held moves the chip to hibernate on the next cycle, whatever the network side requests. In hibernate the state is 10, the level is 00, both enables are low and both holds are high.
- R9: Hibernate is left only on a wake. Power-up follows the R4 sequence. Both holds drop one cycle after the state first reads 00.
- R10: The PLL enable is never high while the oscillator enable is low.
- R11: A hibernate request while the application side is held is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| app_req | input | 2 | Application subsystem power request code |
| net_req | input | 2 | Network subsystem power request code |
| app_hib_req | input | 1 | Application request for hibernate |
| app_wake | input | 1 | Wake event for the application subsystem |
| net_wake | input | 1 | Wake event for the network subsystem |
| reg_lvl | input | 2 | Level currently reported by the regulator |
| pll_lock | input | 1 | PLL lock indication |
| chip_state | output | 2 | Chip power state code |
| vsel | output | 2 | Regulator level select |
| osc_en | output | 1 | Main oscillator enable |
| pll_en | output | 1 | PLL enable |
| app_hold | output | 1 | Reset-hold for the application subsystem |
| net_hold | output | 1 | Reset-hold for the network subsystem |

## Verification
The combining function is driven with every pairing of run, idle and deep requests, plus the reserved code. This separates the one pairing that reaches true deep sleep from the pairings that only hold one side. Separate runs distinguish three paths: a full power-down followed by a network-only wake, a wake landing mid power-down, and hibernate entry and exit. These runs show whether releases are selective and whether the power-down and power-up steps come in the right order with the right gaps. Wakes on unheld subsystems and hibernate requests from a held application side show whether ignored stimulus stays invisible at the outputs.

// File: rtl/pwr_arb_pkg.sv
package pwr_arb_pkg;

    localparam int NSUB = 2;
    localparam int APP  = 0;
    localparam int NET  = 1;

    typedef enum logic [1:0] {
        REQ_RUN  = 2'b00,
        REQ_IDLE = 2'b01,
        REQ_DEEP = 2'b10,
        REQ_RSVD = 2'b11
    } sub_req_e;

    typedef enum logic [1:0] {
        CHIP_ACTIVE = 2'b00,
        CHIP_DEEP   = 2'b01,
        CHIP_HIB    = 2'b10,
        CHIP_MOVING = 2'b11
    } chip_st_e;

    typedef enum logic [1:0] {
        LVL_OFF  = 2'b00,
        LVL_LOW  = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_RSVD = 2'b11
    } vlvl_e;

    typedef enum logic [3:0] {
        SQ_ACTIVE,
        SQ_ENT_PLL,
        SQ_ENT_OSC,
        SQ_ENT_VLT,
        SQ_DEEP,
        SQ_HIB,
        SQ_EX_VLT,
        SQ_EX_OSC,
        SQ_EX_PLL
    } seq_st_e;

    typedef struct packed {
        chip_st_e chip;
        vlvl_e    lvl;
        logic     osc;
        logic     pll;
    } drive_t;

    function automatic logic is_deep(logic [1:0] r);
        return r == REQ_DEEP;
    endfunction

    // Output drive associated with each sequencer state.
    function automatic drive_t drive_of(seq_st_e s);
        drive_t d;
        case (s)
            SQ_ACTIVE:  d = '{CHIP_ACTIVE, LVL_HIGH, 1'b1, 1'b1};
            SQ_ENT_PLL: d = '{CHIP_MOVING, LVL_HIGH, 1'b1, 1'b0};
            SQ_ENT_OSC: d = '{CHIP_MOVING, LVL_HIGH, 1'b0, 1'b0};
            SQ_ENT_VLT: d = '{CHIP_MOVING, LVL_LOW,  1'b0, 1'b0};
            SQ_DEEP:    d = '{CHIP_DEEP,   LVL_LOW,  1'b0, 1'b0};
            SQ_HIB:     d = '{CHIP_HIB,    LVL_OFF,  1'b0, 1'b0};
            SQ_EX_VLT:  d = '{CHIP_MOVING, LVL_HIGH, 1'b0, 1'b0};
            SQ_EX_OSC:  d = '{CHIP_MOVING, LVL_HIGH, 1'b1, 1'b0};
            SQ_EX_PLL:  d = '{CHIP_MOVING, LVL_HIGH, 1'b1, 1'b1};
            default:    d = '{CHIP_ACTIVE, LVL_HIGH, 1'b1, 1'b1};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pwr_sub_hold.sv
module pwr_sub_hold
    import pwr_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] req,
    input  logic       wake,
    input  seq_st_e    st,
    input  logic       rel_all,
    output logic       hold,
    output logic       pend
);

    logic hold_q;
    logic pend_q;
    logic prev_deep;
    logic deep_now;

    assign deep_now = is_deep(req);
    assign hold     = hold_q | (st == SQ_HIB);
    assign pend     = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= 1'b0;
            pend_q    <= 1'b0;
            prev_deep <= 1'b0;
        end else begin
            prev_deep <= deep_now;
            if (rel_all) begin
                // hibernate exit: subsystem restarts with nothing kept
                hold_q <= 1'b0;
                pend_q <= 1'b0;
            end else if (hold) begin
                if (wake) begin
                    pend_q <= 1'b1;
                end
                if (st == SQ_HIB) begin
                    hold_q <= 1'b1;
                end
                if (st == SQ_ACTIVE && pend_q) begin
                    hold_q <= 1'b0;
                    pend_q <= 1'b0;
                end
            end else if (st == SQ_ACTIVE && deep_now && !prev_deep) begin
                hold_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_arb_pkg::*;
#(
    parameter int OSC_SETTLE = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSUB-1:0] hold,
    input  logic [NSUB-1:0] pend,
    input  logic [NSUB-1:0] wake_held,
    input  logic            hib_req,
    input  logic [1:0]      reg_lvl,
    input  logic            pll_lock,
    output seq_st_e         st,
    output logic            rel_all
);

    localparam int CW = $clog2(OSC_SETTLE + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(OSC_SETTLE - 1);

    seq_st_e       nxt;
    logic [CW-1:0] cnt;
    logic          from_hib;
    logic          abort;

    assign abort   = (|pend) | (|wake_held);
    assign rel_all = (st == SQ_ACTIVE) && from_hib;

    always_comb begin
        nxt = st;
        case (st)
            SQ_ACTIVE: begin
                if (hib_req && !hold[APP]) begin
                    nxt = SQ_HIB;
                end else if ((&hold) && !abort && !from_hib) begin
                    nxt = SQ_ENT_PLL;
                end
            end
            SQ_ENT_PLL: nxt = abort ? SQ_EX_VLT : SQ_ENT_OSC;
            SQ_ENT_OSC: nxt = abort ? SQ_EX_VLT : SQ_ENT_VLT;
            SQ_ENT_VLT: begin
                if (abort) begin
                    nxt = SQ_EX_VLT;
                end else if (reg_lvl == LVL_LOW) begin
                    nxt = SQ_DEEP;
                end
            end
            SQ_DEEP: begin
                if (abort) begin
                    nxt = SQ_EX_VLT;
                end
            end
            SQ_HIB: begin
                if (|wake_held) begin
                    nxt = SQ_EX_VLT;
                end
            end
            SQ_EX_VLT: begin
                if (reg_lvl == LVL_HIGH) begin
                    nxt = SQ_EX_OSC;
                end
            end
            SQ_EX_OSC: begin
                if (cnt == CNT_LAST) begin
                    nxt = SQ_EX_PLL;
                end
            end
            SQ_EX_PLL: begin
                if (pll_lock) begin
                    nxt = SQ_ACTIVE;
                end
            end
            default: nxt = SQ_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_ACTIVE;
            cnt      <= '0;
            from_hib <= 1'b0;
        end else begin
            st <= nxt;
            if (st == SQ_EX_OSC) begin
                cnt <= cnt + CW'(1);
            end else begin
                cnt <= '0;
            end
            if (st == SQ_HIB) begin
                from_hib <= 1'b1;
            end else if (st == SQ_ACTIVE) begin
                from_hib <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pwr_arbiter.sv
module pwr_arbiter
    import pwr_arb_pkg::*;
#(
    parameter int OSC_SETTLE = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] app_req,
    input  logic [1:0] net_req,
    input  logic       app_hib_req,
    input  logic       app_wake,
    input  logic       net_wake,
    input  logic [1:0] reg_lvl,
    input  logic       pll_lock,
    output logic [1:0] chip_state,
    output logic [1:0] vsel,
    output logic       osc_en,
    output logic       pll_en,
    output logic       app_hold,
    output logic       net_hold
);

    logic [1:0]      req_v [NSUB];
    logic [NSUB-1:0] wake_v;
    logic [NSUB-1:0] hold_v;
    logic [NSUB-1:0] pend_v;
    logic [NSUB-1:0] wake_held;
    seq_st_e         st;
    logic            rel_all;
    drive_t          drv;

    assign req_v[APP]  = app_req;
    assign req_v[NET]  = net_req;
    assign wake_v[APP] = app_wake;
    assign wake_v[NET] = net_wake;

    generate
        for (genvar i = 0; i < NSUB; i++) begin : g_sub
            pwr_sub_hold u_hold (
                .clk     (clk),
                .rst     (rst),
                .req     (req_v[i]),
                .wake    (wake_v[i]),
                .st      (st),
                .rel_all (rel_all),
                .hold    (hold_v[i]),
                .pend    (pend_v[i])
            );
            assign wake_held[i] = wake_v[i] & hold_v[i];
        end
    endgenerate

    pwr_seq_fsm #(
        .OSC_SETTLE (OSC_SETTLE)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .hold      (hold_v),
        .pend      (pend_v),
        .wake_held (wake_held),
        .hib_req   (app_hib_req),
        .reg_lvl   (reg_lvl),
        .pll_lock  (pll_lock),
        .st        (st),
        .rel_all   (rel_all)
    );

    assign drv        = drive_of(st);
    assign chip_state = drv.chip;
    assign vsel       = drv.lvl;
    assign osc_en     = drv.osc;
    assign pll_en     = drv.pll;
    assign app_hold   = hold_v[APP];
    assign net_hold   = hold_v[NET];

endmodule

// File: rtl/pwr_arbiter_chk.sv
module pwr_arbiter_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] reg_lvl,
    input logic [1:0] chip_state,
    input logic [1:0] vsel,
    input logic       osc_en,
    input logic       pll_en,
    input logic       app_hold,
    input logic       net_hold
);

    // R1
    active_drive_chk: assert property (@(posedge clk) disable iff (rst)
        chip_state == 2'b00 |-> (vsel == 2'b10 && osc_en && pll_en));

    // R3
    deep_drive_chk: assert property (@(posedge clk) disable iff (rst)
        chip_state == 2'b01 |-> (vsel == 2'b01 && !osc_en && !pll_en && app_hold && net_hold));

    // R3
    deep_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (chip_state == 2'b01 && $past(chip_state) == 2'b11) |-> $past(reg_lvl) == 2'b01);

    // R8
    hib_drive_chk: assert property (@(posedge clk) disable iff (rst)
        chip_state == 2'b10 |-> (vsel == 2'b00 && !osc_en && !pll_en && app_hold && net_hold));

    // R4
    app_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(app_hold) |-> (chip_state == 2'b00 && $past(chip_state) == 2'b00));

    // R4
    net_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(net_hold) |-> (chip_state == 2'b00 && $past(chip_state) == 2'b00));

    // R10
    pll_osc_chk: assert property (@(posedge clk) disable iff (rst)
        pll_en |-> osc_en);

endmodule

bind pwr_arbiter pwr_arbiter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_lvl    (reg_lvl),
    .chip_state (chip_state),
    .vsel       (vsel),
    .osc_en     (osc_en),
    .pll_en     (pll_en),
    .app_hold   (app_hold),
    .net_hold   (net_hold)
);

// File: tb/tb_pwr_arbiter.sv
`timescale 1ns/1ps
module tb_pwr_arbiter;

    localparam int SETTLE = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] app_req = 2'b00;
    logic [1:0] net_req = 2'b00;
    logic       app_hib_req = 1'b0;
    logic       app_wake = 1'b0;
    logic       net_wake = 1'b0;
    logic [1:0] reg_lvl;
    logic       pll_lock;
    logic [1:0] chip_state;
    logic [1:0] vsel;
    logic       osc_en;
    logic       pll_en;
    logic       app_hold;
    logic       net_hold;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pwr_arbiter #(.OSC_SETTLE(SETTLE)) dut (
        .clk(clk), .rst(rst), .app_req(app_req), .net_req(net_req),
        .app_hib_req(app_hib_req), .app_wake(app_wake), .net_wake(net_wake),
        .reg_lvl(reg_lvl), .pll_lock(pll_lock), .chip_state(chip_state),
        .vsel(vsel), .osc_en(osc_en), .pll_en(pll_en),
        .app_hold(app_hold), .net_hold(net_hold)
    );

    // regulator: reports the selected level two cycles later
    logic [1:0] lvl_d1;
    logic [1:0] lvl_d2;
    logic [2:0] lock_sr;
    always @(posedge clk) begin
        if (rst) begin
            lvl_d1  <= 2'b10;
            lvl_d2  <= 2'b10;
            lock_sr <= 3'b111;
        end else begin
            lvl_d1  <= vsel;
            lvl_d2  <= lvl_d1;
            lock_sr <= {lock_sr[1:0], pll_en};
        end
    end
    assign reg_lvl  = lvl_d2;
    assign pll_lock = lock_sr[2] & pll_en;

    // app[7:6] net[5:4] state[3:2] app_hold[1] net_hold[0]
    localparam logic [7:0] VEC [10] = '{
        8'b00_00_00_0_0, 8'b00_01_00_0_0, 8'b00_10_00_0_1,
        8'b01_00_00_0_0, 8'b01_01_00_0_0, 8'b01_10_00_0_1,
        8'b10_00_00_1_0, 8'b10_01_00_1_0, 8'b10_10_01_1_1,
        8'b11_10_00_0_1
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        app_req = 2'b00; net_req = 2'b00;
        app_hib_req = 1'b0; app_wake = 1'b0; net_wake = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);
    endtask

    task automatic pulse_app();
        app_wake = 1'b1; step(1); app_wake = 1'b0;
    endtask

    task automatic pulse_net();
        net_wake = 1'b1; step(1); net_wake = 1'b0;
    endtask

    // steps until chip_state matches; returns cycles used or -1
    task automatic wait_state(input logic [1:0] s, input int lim, output int used, output bit saw_deep);
        used = -1;
        saw_deep = 1'b0;
        for (int i = 0; i < lim; i++) begin
            if (chip_state == 2'b01) saw_deep = 1'b1;
            if (chip_state == s) begin
                used = i;
                break;
            end
            step(1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int used;
        bit saw_deep;
        int c_pll, c_osc, c_vlo, c_lvl, c_deep, c_vhi, c_oon, c_pon, c_act, bad_pll;

        // R1 reset state
        do_reset();
        check("R1 reset state", chip_state, 0);
        check("R1 reset vsel", vsel, 2);
        check("R1 reset osc/pll", {osc_en, pll_en}, 3);
        check("R1 reset holds", {app_hold, net_hold}, 0);

        // R1 R2 R3 request combination table
        for (int v = 0; v < 10; v++) begin
            do_reset();
            app_req = VEC[v][7:6];
            net_req = VEC[v][5:4];
            step(25);
            check("R1 table state", chip_state, VEC[v][3:2]);
            check("R2 table holds", {app_hold, net_hold}, VEC[v][1:0]);
            check("R1 table vsel", vsel, (VEC[v][3:2] == 2'b01) ? 1 : 2);
        end

        // R2 R3 power-down order
        do_reset();
        app_req = 2'b10;
        step(2);
        check("R2 app held", app_hold, 1);
        check("R2 chip stays active", chip_state, 0);
        net_req = 2'b10;
        c_pll = -1; c_osc = -1; c_vlo = -1; c_lvl = -1; c_deep = -1;
        for (int i = 0; i < 30; i++) begin
            step(1);
            if (c_pll < 0 && !pll_en) begin
                c_pll = i;
                check("R3 moving code", chip_state, 3);
            end
            if (c_osc < 0 && !osc_en) c_osc = i;
            if (c_vlo < 0 && vsel == 2'b01) c_vlo = i;
            if (c_lvl < 0 && reg_lvl == 2'b01) c_lvl = i;
            if (c_deep < 0 && chip_state == 2'b01) c_deep = i;
        end
        check("R3 osc after pll", c_osc - c_pll, 1);
        check("R3 level after osc", c_vlo - c_osc, 1);
        check("R3 deep after level ack", c_deep - c_lvl, 1);
        check("R3 deep holds", {app_hold, net_hold}, 3);

        // R4 R5 R10 network-only wake
        app_req = 2'b00; net_req = 2'b00;
        pulse_net();
        c_vhi = -1; c_oon = -1; c_pon = -1; c_act = -1; bad_pll = 0;
        for (int i = 0; i < 60 && c_act < 0; i++) begin
            if (pll_en && !osc_en) bad_pll++;
            if (c_vhi < 0 && vsel == 2'b10) c_vhi = i;
            if (c_oon < 0 && osc_en) c_oon = i;
            if (c_pon < 0 && pll_en) c_pon = i;
            if (chip_state == 2'b00) c_act = i;
            else step(1);
        end
        check("R4 active reached", c_act >= 0, 1);
        check("R4 osc after level", c_oon > c_vhi, 1);
        check("R4 settle count", c_pon - c_oon, SETTLE);
        check("R10 pll without osc", bad_pll, 0);
        check("R4 hold kept first active cycle", net_hold, 1);
        step(1);
        check("R4 net released", net_hold, 0);
        step(5);
        check("R5 app still held", app_hold, 1);

        // R7 wake on unheld subsystem
        pulse_net();
        step(2);
        check("R7 net unaffected", {net_hold, chip_state}, 0);
        check("R7 app unaffected", app_hold, 1);
        pulse_app();
        step(1);
        check("R4 app released in active", app_hold, 0);

        // R6 abort during power-down
        do_reset();
        app_req = 2'b10; net_req = 2'b10;
        wait_state(2'b11, 10, used, saw_deep);
        check("R6 entry started", used >= 0, 1);
        pulse_app();
        wait_state(2'b00, 60, used, saw_deep);
        check("R6 active again", used >= 0, 1);
        check("R6 deep avoided", saw_deep, 0);
        step(2);
        check("R6 holds after abort", {app_hold, net_hold}, 1);

        // R11 hibernate ignored while app held
        do_reset();
        app_req = 2'b10;
        step(2);
        app_hib_req = 1'b1;
        step(3);
        check("R11 hib ignored", chip_state, 0);
        check("R11 app hold", app_hold, 1);
        app_hib_req = 1'b0;

        // R8 R9 hibernate entry and exit
        do_reset();
        net_req = 2'b10;
        step(2);
        app_hib_req = 1'b1;
        step(1);
        app_hib_req = 1'b0;
        check("R8 hib state", chip_state, 2);
        check("R8 hib level", vsel, 0);
        check("R8 hib enables", {osc_en, pll_en}, 0);
        check("R8 hib holds", {app_hold, net_hold}, 3);
        net_req = 2'b00;
        step(10);
        check("R9 hib kept without wake", chip_state, 2);
        pulse_net();
        wait_state(2'b00, 60, used, saw_deep);
        check("R9 active after hib", used >= 0, 1);
        check("R9 holds on first active", {app_hold, net_hold}, 3);
        step(1);
        check("R9 both released", {app_hold, net_hold}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule